// File: doc/BRIEF.md
# GPIO Port Controller With Pull Control

This block manages nine 8-bit general-purpose I/O ports through a small synchronous register bus. Software writes a per-pin direction register and an output latch for each port. The block drives pad output-enable and output-value lines from those registers. Pad inputs pass through a two-flop synchronizer before software can read them.

Two pull-control registers switch on pull resistors for groups of pins, one group per bit. Ports 0 and 3, and pins 0–5 of port 1, have pull-downs. Every other group has pull-ups. A pull never acts on a plain pin that is set as an output.

Two bits also gate output drivers:
- Bit 0 of the output-control register enables the drivers of port 1 pins 0–5. While it is set, their pull-downs are off.
- Bit 0 of pull register A is shared by ports 0 and 3. When this bit is set, those ports stop driving and their pull-downs turn on.

The read data comes straight from the registers and the synchronizer, with no register stage in between. Software sees a read result in the same cycle it presents the address.

Top module: `gpio_pull_ctrl`

## Requirements
- R1: A direction bit of 0 makes its pin an input with pad_oe low. A 1 makes it an output. On a plain pin, pad_oe equals the direction bit from the clock edge that writes it.
- R2: pad_out always carries the output latch. A read of a data register returns the latch bit for every pin whose direction bit is 1.
- R3: A read of a data register returns the pad value for every pin whose direction bit is 0. That value appears two clock edges after the pad changes, not one. Writing the data register of an input pin changes only the latch. pad_oe stays low until the direction bit becomes 1, and the pin then drives the written value.
- R4: Port 1 pins 0–5 drive only when bit 0 of the output-control register (address 0x03) is 1, and only for pins whose direction bit is 1. Their pull-down follows pull A bit 0 only while the control bit is 0 and the pin is an input.
- R5: Reset clears every direction, latch, pull and control register. After reset, all pad_oe, pad_pu and pad_pd bits are 0, and every mapped register reads 0.
- R6: For ports 0 and 3, pull A bit 0 = 1 forces pad_oe low and pad_pd high on all pins, whatever the direction. Pull A bit 0 = 0 gives pad_oe = direction and pad_pd = 0.
- R7: For a plain pin, pull-up is enabled only when its group bit is 1 and its direction bit is 0.
- R8: Pull register A (address 0x16) maps bits to pin groups as follows. Bits 6–7 read 0 whatever was written.

  | Bit | Pull | Pins |
  |---|---|---|
  | 0 | pull-down | ports 0 and 3, port 1 pins 0–5 |
  | 1 | pull-up | port 1 pins 6–7 |
  | 2 | pull-up | port 2 |
  | 3 | pull-up | port 8 pins 0–1 |
  | 4 | pull-up | port 4 pins 0–3 |
  | 5 | pull-up | port 4 pins 4–7 |

- R9: Pull register B (address 0x17) maps bits 0–5 to pull-ups on the low and high nibbles of ports 5, 6 and 7 in turn: bit 0 is port 5 low, bit 1 port 5 high, and so on up to bit 5 for port 7 high. Bits 6–7 read 0. Port 8 pins 2–7 have no pull.
- R10: The data register of port n sits at 0x40+n and its direction register at 0x50+n. Output-control bits 1–7 read 0. An unmapped address reads 0 and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 72 | Pad input values, port n at bits 8n+7:8n |
| pad_out | output | 72 | Pad output values (the latches) |
| pad_oe | output | 72 | Pad output enables |
| pad_pu | output | 72 | Pad pull-up enables |
| pad_pd | output | 72 | Pad pull-down enables |

## Verification
A wrong direction bit or a wrong gate decision shows up on pad_oe from the edge after the write. A pull mapped to the wrong group shows up at once as a misplaced bit on pad_pu or pad_pd. A synchronizer with the wrong depth shows at the port as an input value that reaches bus_rdata one edge early or late. The bench probes that edge directly. A register that ignores its address or mask shows up on the very next read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PW     = 8;
  localparam int NPORT  = 9;
  localparam int NPINS  = PW * NPORT;
  localparam int AW     = 8;

  localparam logic [AW-1:0] A_CTRL      = 8'h03;
  localparam logic [AW-1:0] A_PULLA     = 8'h16;
  localparam logic [AW-1:0] A_PULLB     = 8'h17;
  localparam logic [AW-1:0] A_DATA_BASE = 8'h40;
  localparam logic [AW-1:0] A_DIR_BASE  = 8'h50;
  localparam logic [PW-1:0] PULL_MASK   = 8'h3F;

  typedef enum logic [1:0] {PIN_PLAIN, PIN_SHARED, PIN_GATED} pin_kind_e;

  // how a pin's driver is gated
  function automatic pin_kind_e pin_kind(input int p, input int b);
    if (p == 0 || p == 3) return PIN_SHARED;
    if (p == 1 && b < 6)  return PIN_GATED;
    return PIN_PLAIN;
  endfunction

  // index into {pullb, pulla}, or -1 when the pin has no pull
  function automatic int pull_index(input int p, input int b);
    case (p)
      0, 3: return 0;
      1:    return (b < 6) ? 0 : 1;
      2:    return 2;
      4:    return (b < 4) ? 4 : 5;
      5:    return (b < 4) ? 8 : 9;
      6:    return (b < 4) ? 10 : 11;
      7:    return (b < 4) ? 12 : 13;
      8:    return (b < 2) ? 3 : -1;
      default: return -1;
    endcase
  endfunction

  // value returned on a data read: latch for outputs, pad for inputs
  function automatic logic [PW-1:0] port_view(input logic [PW-1:0] dir,
                                              input logic [PW-1:0] latch,
                                              input logic [PW-1:0] pad);
    return (dir & latch) | (~dir & pad);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [PW-1:0]    bus_wdata,
  input  logic             bus_we,
  output logic [PW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_sync,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] latch_q,
  output logic [PW-1:0]    pulla_q,
  output logic [PW-1:0]    pullb_q,
  output logic             ctrl_q
);
  // named write events, one per register
  logic wr_ctrl, wr_pulla, wr_pullb;
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_pulla = bus_we && (bus_addr == A_PULLA);
  assign wr_pullb = bus_we && (bus_addr == A_PULLB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      pulla_q <= '0;
      pullb_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= bus_wdata[0];
      if (wr_pulla) pulla_q <= bus_wdata & PULL_MASK;
      if (wr_pullb) pullb_q <= bus_wdata & PULL_MASK;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic wr_data, wr_dir;
    assign wr_data = bus_we && (bus_addr == (A_DATA_BASE + AW'(p)));
    assign wr_dir  = bus_we && (bus_addr == (A_DIR_BASE + AW'(p)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[p*PW +: PW]   <= '0;
        latch_q[p*PW +: PW] <= '0;
      end else begin
        if (wr_dir)  dir_q[p*PW +: PW]   <= bus_wdata;
        if (wr_data) latch_q[p*PW +: PW] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)  bus_rdata = {{(PW-1){1'b0}}, ctrl_q};
    if (bus_addr == A_PULLA) bus_rdata = pulla_q;
    if (bus_addr == A_PULLB) bus_rdata = pullb_q;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == (A_DATA_BASE + AW'(p)))
        bus_rdata = port_view(dir_q[p*PW +: PW], latch_q[p*PW +: PW],
                              pad_sync[p*PW +: PW]);
      if (bus_addr == (A_DIR_BASE + AW'(p)))
        bus_rdata = dir_q[p*PW +: PW];
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(bus_wdata[0])); // R10
  AST_PULLA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulla |=> pulla_q == ($past(bus_wdata) & PULL_MASK)); // R8
  AST_PULLB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pullb |=> pullb_q == ($past(bus_wdata) & PULL_MASK)); // R9
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] dir_q,
  input  logic [PW-1:0]    pulla_q,
  input  logic [PW-1:0]    pullb_q,
  input  logic             ctrl_q,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd
);
  logic [2*PW-1:0] pulls;
  assign pulls = {pullb_q, pulla_q};

  // shared output/pull-down bit for ports 0 and 3 and port 1 low pins
  logic shared_pd;
  assign shared_pd = pulla_q[0];

  logic unused_pull_bits;
  assign unused_pull_bits = ^{pulla_q[PW-1:6], pullb_q[PW-1:6]};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar b = 0; b < PW; b++) begin : g_pin
      localparam int        I    = p * PW + b;
      localparam pin_kind_e KIND = pin_kind(p, b);
      localparam int        PIDX = pull_index(p, b);

      if (KIND == PIN_SHARED) begin : g_shared
        assign pad_oe[I] = dir_q[I] & ~shared_pd;
        assign pad_pd[I] = shared_pd;
        assign pad_pu[I] = 1'b0;
        AST_SHARED_PD_STOPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
          pad_pd[I] |-> !pad_oe[I]); // R6
      end else if (KIND == PIN_GATED) begin : g_gated
        assign pad_oe[I] = dir_q[I] & ctrl_q;
        assign pad_pd[I] = shared_pd & ~dir_q[I] & ~ctrl_q;
        assign pad_pu[I] = 1'b0;
        AST_GATED_NO_PULL_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
          ctrl_q |-> !pad_pd[I]); // R4
      end else begin : g_plain
        assign pad_oe[I] = dir_q[I];
        assign pad_pd[I] = 1'b0;
        if (PIDX >= 0) begin : g_pull
          assign pad_pu[I] = pulls[PIDX] & ~dir_q[I];
        end else begin : g_nopull
          assign pad_pu[I] = 1'b0;
        end
        AST_PLAIN_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
          pad_pu[I] |-> !dir_q[I]); // R7
      end

      AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[I] |-> dir_q[I]); // R1
    end
  end
endmodule

// File: rtl/gpio_pull_ctrl.sv
module gpio_pull_ctrl
  import gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [PW-1:0]    bus_wdata,
  input  logic             bus_we,
  output logic [PW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd
);
  logic [NPINS-1:0] pad_sync, dir_q, latch_q;
  logic [PW-1:0]    pulla_q, pullb_q;
  logic             ctrl_q;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_sync(pad_sync),
    .dir_q(dir_q), .latch_q(latch_q), .pulla_q(pulla_q), .pullb_q(pullb_q),
    .ctrl_q(ctrl_q)
  );

  gpio_padctl u_padctl (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .pulla_q(pulla_q),
    .pullb_q(pullb_q), .ctrl_q(ctrl_q), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd)
  );

  assign pad_out = latch_q;

  AST_OUT_FOLLOWS_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DATA_BASE) |=> pad_out[PW-1:0] == $past(bus_wdata)); // R2
endmodule

// File: tb/gpio_pull_ctrl_tb.sv
module gpio_pull_ctrl_tb;
  localparam int NP = 72;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0, bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  gpio_pull_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
    logic [3:0] port;
    logic [7:0] oe;
    logic [7:0] pu;
    logic [7:0] pd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{8'h52, 8'hF0, 4'd2, 8'hF0, 8'h00, 8'h00},  // R1 plain dir
    '{8'h16, 8'h04, 4'd2, 8'hF0, 8'h0F, 8'h00},  // R7 R8 port2 pull-up on inputs
    '{8'h50, 8'hFF, 4'd0, 8'hFF, 8'h00, 8'h00},  // R6 shared bit 0 -> drive
    '{8'h16, 8'h05, 4'd0, 8'h00, 8'h00, 8'hFF},  // R6 shared bit 1 -> pull-down
    '{8'h51, 8'h0F, 4'd1, 8'h00, 8'h00, 8'h30},  // R4 gate off, pd on inputs
    '{8'h03, 8'h01, 4'd1, 8'h0F, 8'h00, 8'h00},  // R4 gate on, pd ignored
    '{8'h16, 8'h07, 4'd1, 8'h0F, 8'hC0, 8'h00},  // R8 bit1 port1 high pins
    '{8'h51, 8'hFF, 4'd1, 8'hFF, 8'h00, 8'h00},  // R7 outputs mask pull-up
    '{8'h17, 8'h21, 4'd7, 8'h00, 8'hF0, 8'h00},  // R9 bit5 port7 high
    '{8'h55, 8'h03, 4'd5, 8'h03, 8'h0C, 8'h00},  // R9 bit0 port5 low, R7
    '{8'h16, 8'h18, 4'd8, 8'h00, 8'h03, 8'h00},  // R8 bit3 port8 pins 0-1
    '{8'h53, 8'hAA, 4'd3, 8'hAA, 8'h00, 8'h00},  // R6 port3 drive
    '{8'h16, 8'h21, 4'd3, 8'h00, 8'h00, 8'hFF},  // R6 port3 pull-down
    '{8'h16, 8'h20, 4'd4, 8'h00, 8'hF0, 8'h00}   // R8 bit5 port4 high
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    do_reset();

    // R5 reset state
    chk("R5 oe", (|pad_oe) ? 8'h01 : 8'h00, 8'h00);
    chk("R5 pu", (|pad_pu) ? 8'h01 : 8'h00, 8'h00);
    chk("R5 pd", (|pad_pd) ? 8'h01 : 8'h00, 8'h00);
    rd(8'h03, r); chk("R5 ctrl", r, 8'h00);
    rd(8'h16, r); chk("R5 pulla", r, 8'h00);
    rd(8'h17, r); chk("R5 pullb", r, 8'h00);
    rd(8'h58, r); chk("R5 dir8", r, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VT[i].addr, VT[i].data);
      chk($sformatf("table[%0d] oe", i), pad_oe[VT[i].port*8 +: 8], VT[i].oe);
      chk($sformatf("table[%0d] pu", i), pad_pu[VT[i].port*8 +: 8], VT[i].pu);
      chk($sformatf("table[%0d] pd", i), pad_pd[VT[i].port*8 +: 8], VT[i].pd);
    end

    // R2 output pins read the latch, pad_out carries it
    wr(8'h56, 8'hFF);
    wr(8'h46, 8'h5A);
    pad_in[48 +: 8] = 8'hA5;
    repeat (3) @(negedge clk);
    rd(8'h46, r); chk("R2 read latch", r, 8'h5A);
    chk("R2 pad_out", pad_out[48 +: 8], 8'h5A);

    // R3 input pins read the synchronized pad
    wr(8'h56, 8'h0F);
    rd(8'h46, r); chk("R3 mixed read", r, 8'hAA);
    pad_in[48 +: 8] = 8'h35;
    @(negedge clk);
    rd(8'h46, r); chk("R3 one edge old", r, 8'hAA);
    @(negedge clk);
    rd(8'h46, r); chk("R3 two edges new", r, 8'h3A);

    // R3 write to an input pin touches only the latch
    wr(8'h57, 8'h00);
    wr(8'h47, 8'h3C);
    chk("R3 input not driven", pad_oe[56 +: 8], 8'h00);
    chk("R3 latch written", pad_out[56 +: 8], 8'h3C);
    wr(8'h57, 8'hFF);
    chk("R3 later drive oe", pad_oe[56 +: 8], 8'hFF);
    rd(8'h47, r); chk("R3 later read", r, 8'h3C);

    // R8 R9 unused pull bits read zero
    wr(8'h16, 8'hFF);
    rd(8'h16, r); chk("R8 pulla mask", r, 8'h3F);
    wr(8'h17, 8'hFF);
    rd(8'h17, r); chk("R9 pullb mask", r, 8'h3F);
    chk("R9 port8 high no pull", pad_pu[64 +: 8], 8'h03);

    // R10 address map
    wr(8'h99, 8'hFF);
    rd(8'h99, r); chk("R10 unmapped", r, 8'h00);
    rd(8'h03, r); chk("R10 ctrl set", r, 8'h01);
    wr(8'h03, 8'hFE);
    rd(8'h03, r); chk("R10 ctrl bit0 only", r, 8'h00);
    chk("R4 gate off stops drive", pad_oe[13:8], 6'h00);
    wr(8'h03, 8'h01);
    rd(8'h51, r); chk("R10 dir1 read", r, 8'hFF);

    // R5 reset after configuration
    do_reset();
    rd(8'h03, r); chk("R5 ctrl cleared", r, 8'h00);
    rd(8'h47, r); chk("R5 latch cleared", r, 8'h00);
    chk("R5 port1 oe", pad_oe[8 +: 8], 8'h00);
    chk("R5 port7 out", pad_out[56 +: 8], 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule